// File: doc/BRIEF.md
# DMA Packet Countdown Register

This block holds an 8-bit count that caps how many packets an automatic DMA mode moves before firmware is notified. Firmware loads the count through a simple register write port and can read it back at any time. The DMA engine sends a one-cycle completion pulse for each packet that finishes successfully. On receive, that means the packet arrived without error and was then stored to memory. On transmit, it means the packet was fetched from memory and then sent without error. Pulses are only counted while automatic mode is enabled.

Each counted completion lowers the count by one, and the count stops at zero. The count-done event does not fire when the count reaches zero. It fires on the next counted completion, the one that arrives while the count already reads zero. To move N packets, firmware loads N-1, and the event then marks the Nth completion. A firmware write in the same cycle as a decrement wins, and the decrement is dropped. The event flag stays set until the event logic sends a one-cycle clear strobe. If a clear arrives in the same cycle as a new event, the flag stays set.

Two small state machines do the work. The count tracker has two states. `CNT_EMPTY` means the count is zero and `CNT_ACTIVE` means it is nonzero. It moves from `CNT_EMPTY` to `CNT_ACTIVE` on a write of a nonzero value. It moves from `CNT_ACTIVE` to `CNT_EMPTY` on a write of zero, or on a counted completion while the count is one. The event flag also has two states, `EVT_CLEAR` and `EVT_PENDING`. It moves from `EVT_CLEAR` to `EVT_PENDING` on a counted completion while the tracker is in `CNT_EMPTY`. It returns from `EVT_PENDING` to `EVT_CLEAR` on a clear strobe, but only in a cycle with no new event.

Top module: `pkt_countdown`

## Requirements
- R1: After reset the count reads 0 and the count-done flag is 0.
- R2: A register write stores the write data, and the stored value appears on the read data output from the next cycle on.
- R3: A counted completion (completion pulse high while automatic mode is enabled) with no write in the same cycle lowers a nonzero count by exactly one, including from 255.
- R4: A completion pulse while automatic mode is disabled leaves both the count and the flag unchanged.
- R5: A counted completion while the count is zero leaves the count at zero; the count never wraps.
- R6: The count-done flag is set by a counted completion that arrives while the count already reads zero, and is not set by the completion that brings the count down to zero.
- R7: When a write and a counted completion fall in the same cycle, the written value is stored and no decrement is applied.
- R8: The count-done flag stays set until a clear strobe arrives, and it reads 0 in the cycle after that strobe.
- R9: A clear strobe in the same cycle as a new count-done event leaves the flag set.
- R10: After a load of N-1, the flag first rises after the Nth counted completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Automatic DMA mode enabled; completions are counted only while high |
| pkt_done | input | 1 | One-cycle pulse for each successfully completed packet |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current count |
| evt_clr | input | 1 | One-cycle clear strobe for the count-done flag |
| cnt_done_evt | output | 1 | Sticky count-done event flag |

## Verification
The assertions check these rules on every cycle:
- a counted completion lowers a nonzero count by exactly one, and a zero count stays at zero;
- a write always wins over a decrement;
- with no write and no counted completion, the count holds;
- the flag rises on a completion at zero, holds while nothing clears it, and never rises without a cause.

Some behaviours depend on a whole sequence, and only the bench scenarios can show them:
- a load of N-1 produces the event on exactly the Nth packet and not on the (N-1)th;
- completions are ignored while automatic mode is off;
- the flag survives a clear that coincides with a new event.

// File: rtl/pkt_cnt_pkg.sv
package pkt_cnt_pkg;

    // Count tracker: EMPTY while the stored count is zero, ACTIVE otherwise
    typedef enum logic {
        CNT_EMPTY  = 1'b0,
        CNT_ACTIVE = 1'b1
    } cnt_state_e;

    // Count-done event flag
    typedef enum logic {
        EVT_CLEAR   = 1'b0,
        EVT_PENDING = 1'b1
    } evt_state_e;

endpackage

// File: rtl/pkt_cnt_core.sv
module pkt_cnt_core
    import pkt_cnt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             zero_hit
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_EMPTY;
            count_q <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // Next state: a write decides alone; otherwise a tick at one empties
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_EMPTY: begin
                if (wr_en && (wr_data != CNT_ZERO))
                    state_d = CNT_ACTIVE;
            end
            CNT_ACTIVE: begin
                if (wr_en)
                    state_d = (wr_data == CNT_ZERO) ? CNT_EMPTY : CNT_ACTIVE;
                else if (tick && (count_q == CNT_ONE))
                    state_d = CNT_EMPTY;
            end
            default: state_d = CNT_EMPTY;
        endcase
    end

    // Datapath and outputs
    always_comb begin
        count_d  = count_q;
        zero_hit = 1'b0;
        unique case (state_q)
            CNT_EMPTY: begin
                zero_hit = tick;
                if (wr_en)
                    count_d = wr_data;
            end
            CNT_ACTIVE: begin
                if (wr_en)
                    count_d = wr_data;
                else if (tick)
                    count_d = count_q - CNT_ONE;
            end
            default: count_d = CNT_ZERO;
        endcase
    end

    assign count = count_q;

endmodule

// File: rtl/pkt_evt_flag.sv
module pkt_evt_flag
    import pkt_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);

    evt_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= EVT_CLEAR;
        else
            state_q <= state_d;
    end

    // Next state: set dominates clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EVT_CLEAR: begin
                if (set_req)
                    state_d = EVT_PENDING;
            end
            EVT_PENDING: begin
                if (clr_req && !set_req)
                    state_d = EVT_CLEAR;
            end
            default: state_d = EVT_CLEAR;
        endcase
    end

    // Output
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            EVT_CLEAR:   flag = 1'b0;
            EVT_PENDING: flag = 1'b1;
            default:     flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/pkt_countdown.sv
module pkt_countdown
    import pkt_cnt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             pkt_done,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             evt_clr,
    output logic             cnt_done_evt
);

    logic tick;
    logic zero_hit;

    // Completions count only in automatic mode
    assign tick = auto_en & pkt_done;

    pkt_cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .tick     (tick),
        .count    (reg_rdata),
        .zero_hit (zero_hit)
    );

    pkt_evt_flag u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (zero_hit),
        .clr_req (evt_clr),
        .flag    (cnt_done_evt)
    );

endmodule

// File: rtl/pkt_countdown_chk.sv
module pkt_countdown_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_en,
    input logic             pkt_done,
    input logic             reg_wr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] reg_rdata,
    input logic             evt_clr,
    input logic             cnt_done_evt
);

    logic counted;
    assign counted = auto_en && pkt_done;

    // R2 R7
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata == $past(reg_wdata)));

    // R3
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && counted && reg_rdata != '0) |=> (reg_rdata == $past(reg_rdata) - 1'b1));

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && counted && reg_rdata == '0) |=> (reg_rdata == '0));

    // R4
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !counted) |=> $stable(reg_rdata));

    // R6 R9
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counted && reg_rdata == '0) |=> cnt_done_evt);

    // R8
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_done_evt && !evt_clr) |=> cnt_done_evt);

    // R6
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_done_evt && !(counted && reg_rdata == '0)) |=> !cnt_done_evt);

endmodule

bind pkt_countdown pkt_countdown_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_en      (auto_en),
    .pkt_done     (pkt_done),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .evt_clr      (evt_clr),
    .cnt_done_evt (cnt_done_evt)
);

// File: tb/pkt_countdown_test.sv
`timescale 1ns/1ps
module pkt_countdown_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_en = 1'b0;
    logic       pkt_done = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       evt_clr = 1'b0;
    logic       cnt_done_evt;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    // Scoreboard queues
    logic [7:0] exp_cnt[$];
    logic       exp_evt[$];
    string      exp_tag[$];

    // Reference state
    logic [7:0] m_cnt = '0;
    logic       m_evt = 1'b0;

    always #2.5 clk = ~clk;

    pkt_countdown uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_en      (auto_en),
        .pkt_done     (pkt_done),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .evt_clr      (evt_clr),
        .cnt_done_evt (cnt_done_evt)
    );

    task automatic compare(input logic [7:0] c, input logic e, input string tag);
        checks++;
        if (reg_rdata !== c || cnt_done_evt !== e) begin
            fails++;
            $display("FAIL %s: count=%0d evt=%0b, expected count=%0d evt=%0b",
                     tag, reg_rdata, cnt_done_evt, c, e);
        end
    endtask

    // Driver: one cycle of stimulus, expected result pushed for after the edge
    task automatic step(input logic wr, input logic [7:0] wd, input logic au,
                        input logic dn, input logic cl, input string tag);
        logic hit;
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd; auto_en = au; pkt_done = dn; evt_clr = cl;
        hit = au && dn && (m_cnt == 8'd0);
        if (wr) m_cnt = wd;
        else if (au && dn && m_cnt != 8'd0) m_cnt = m_cnt - 8'd1;
        if (hit) m_evt = 1'b1;
        else if (cl) m_evt = 1'b0;
        exp_cnt.push_back(m_cnt);
        exp_evt.push_back(m_evt);
        exp_tag.push_back(tag);
    endtask

    // Monitor: samples after the edge
    always @(posedge clk) begin
        #1.5;
        if (exp_cnt.size() > 0) begin
            logic [7:0] c;
            logic       e;
            string      t;
            c = exp_cnt.pop_front();
            e = exp_evt.pop_front();
            t = exp_tag.pop_front();
            compare(c, e, t);
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(8'd0, 1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(8'd0, 1'b0, "R1 after release");

        step(1, 8'd5, 1, 0, 0, "R2 load 5");
        step(0, 8'd0, 1, 0, 0, "R2 hold");
        step(0, 8'd0, 1, 1, 0, "R3 5->4");
        step(0, 8'd0, 1, 1, 0, "R3 4->3");
        step(0, 8'd0, 0, 1, 0, "R4 disabled completion");
        step(0, 8'd0, 0, 1, 0, "R4 disabled again");
        step(1, 8'd9, 1, 1, 0, "R7 write beats decrement");
        step(1, 8'd1, 1, 0, 0, "R2 load 1");
        step(0, 8'd0, 1, 1, 0, "R6 reach zero no event");
        step(0, 8'd0, 1, 0, 0, "R6 idle at zero");
        step(0, 8'd0, 1, 1, 0, "R6 event at zero");
        step(0, 8'd0, 1, 1, 0, "R5 stays zero");
        step(0, 8'd0, 1, 0, 0, "R8 sticky");
        step(0, 8'd0, 0, 1, 1, "R4 disabled no set, R8 clear");
        step(0, 8'd0, 1, 0, 0, "R8 stays clear");
        step(0, 8'd0, 1, 1, 0, "R6 set again");
        step(0, 8'd0, 1, 1, 1, "R9 clear with set");
        step(0, 8'd0, 1, 0, 1, "R8 clear");
        step(1, 8'd0, 1, 1, 0, "R7 write zero with tick at zero");
        step(0, 8'd0, 1, 0, 1, "R8 clear after");
        step(1, 8'd255, 1, 0, 0, "R2 load 255");
        step(0, 8'd0, 1, 1, 0, "R3 255->254");

        // R10: N = 4, load 3
        step(1, 8'd3, 1, 0, 0, "R10 load N-1");
        for (int i = 1; i <= 4; i++) begin
            step(0, 8'd0, 1, 1, 0, $sformatf("R10 completion %0d", i));
            step(0, 8'd0, 1, 0, 0, "R10 gap");
        end
        step(0, 8'd0, 1, 0, 1, "R8 final clear");
        step(0, 8'd0, 1, 0, 0, "R8 final idle");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule